// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O port behind a simple synchronous register port. Software writes an output value and a per-pin direction, and reads back the pin levels after they have passed through a two-stage synchronizer. The output value and the direction leave the block on separate buses, so an outside pad ring can build tri-state or open-drain drivers from them.

Each pin has its own interrupt detector. A 2-bit code picks low level, high level, rising edge or falling edge. A separate any-edge bit per pin overrides that code. A detected condition sets a sticky pending bit whether or not the pin is masked. Software clears a pending bit by writing a one to it. A single registered interrupt line is high when any pending bit is also enabled in the mask register.

The register port takes a byte address, a write strobe and a full 32-bit write word, with no byte enables. Read data is registered and appears one clock after the address is presented.

Top module: `gpio_irq_port`

## Requirements
- R1: The output-value register (word offset 0x00) drives `pin_out` and reads back the value last written, never the pin level.
- R2: The direction register (offset 0x04) drives `pin_oe`, and a 1 in a bit means that pin is an output.
- R3: The pad register (offset 0x08) returns `pin_in` after a two-flop synchronizer, whatever the direction setting. Writes to it have no effect.
- R4: Trigger codes are 0 = low level, 1 = high level, 2 = rising edge and 3 = falling edge. Pin n below 16 takes its code from bits [2n+1:2n] of the word at 0x0C. Pin n of 16 or more takes it from bits [2(n-16)+1:2(n-16)] of the word at 0x10.
- R5: A 1 in a pin's bit of the any-edge register (offset 0x1C) makes that pin trigger on both edges, and its 2-bit code is then ignored, including the level codes.
- R6: The pending register (offset 0x18) is write-one-to-clear. Writing 0 to a bit leaves it unchanged. If a new detection and a clear hit the same bit in the same cycle, the bit stays set.
- R7: A pending bit is set on every cycle its condition holds, even while the pin is masked. A level condition that is still present sets the bit again right after a clear.
- R8: `irq` is a registered OR over (pending AND mask), where the mask register sits at offset 0x14. With an all-zero mask, `irq` is low on the next cycle.
- R9: After reset, the output-value, direction, mask, both config words, any-edge register and `irq` are all zero.
- R10: Reads of an address outside the eight word offsets 0x00 to 0x1C, or of a misaligned address, return zero, and writes to such addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output value for each pin |
| pin_oe | output | 32 | Output enable for each pin |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `pin_in` holds each level for at least three clocks, so that the synchronizer output settles to the input. They also assume that edges come only from real level changes between settled samples. The stimulus changes the pins only on falling clock edges and then holds them for six clocks before checking anything. Every register access, except for the deliberate unmapped and misaligned ones, uses a word-aligned address, and reset is held for several clocks so that no check reaches back into the reset period.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_code_e;

  // Word slot selected by address bits [4:2]
  typedef enum logic [2:0] {
    SEL_OUTV   = 3'd0,
    SEL_DIR    = 3'd1,
    SEL_PAD    = 3'd2,
    SEL_CFG_LO = 3'd3,
    SEL_CFG_HI = 3'd4,
    SEL_MASK   = 3'd5,
    SEL_PEND   = 3'd6,
    SEL_ANYE   = 3'd7
  } reg_sel_e;

  localparam int unsigned SEL_LSB = 2;
  localparam int unsigned SEL_W   = 3;

  function automatic logic trig_hit(input trig_code_e code, input logic cur, input logic old);
    unique case (code)
      TRIG_LOW:  return !cur;
      TRIG_HIGH: return cur;
      TRIG_RISE: return cur && !old;
      TRIG_FALL: return !cur && old;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) begin
        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk
      // R3: an input held steady through the chain shows up unchanged
      a_r3_settled_level: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $stable(din) && $past($stable(din)))
          |-> (dout == din));
    end
  endgenerate

endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PINS = 32
) (
  input  logic [PINS-1:0]   cur,
  input  logic [PINS-1:0]   old,
  input  logic [2*PINS-1:0] codes,
  input  logic [PINS-1:0]   any_edge,
  output logic [PINS-1:0]   hit
);

  generate
    for (genvar i = 0; i < PINS; i++) begin : g_pin
      logic code_hit;
      assign code_hit = trig_hit(trig_code_e'(codes[2*i +: 2]), cur[i], old[i]);
      assign hit[i]   = any_edge[i] ? (cur[i] ^ old[i]) : code_hit;
    end
  endgenerate

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int unsigned PINS = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] set_vec,
  input  logic [PINS-1:0] clr_vec,
  input  logic [PINS-1:0] mask,
  output logic [PINS-1:0] pend,
  output logic            irq
);

  logic [PINS-1:0] pend_q;
  logic            irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~clr_vec) | set_vec;
      irq_q  <= |(pend_q & mask);
    end
  end

  assign pend = pend_q;
  assign irq  = irq_q;

  // R7: a detection always lands in the pending register
  a_r7_capture: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(set_vec) & ~pend_q) == '0));

  // R7: a pending bit that is not cleared stays set
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(pend_q) & ~$past(clr_vec)) & ~pend_q) == '0));

  // R6: a clear without a simultaneous detection empties the bit
  a_r6_clear_takes: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(clr_vec) & ~$past(set_vec) & pend_q) == '0));

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PINS        = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic              irq
);

  localparam int unsigned SEL_MSB = SEL_LSB + SEL_W - 1;
  localparam int unsigned HALF    = PINS / 2;

  logic [PINS-1:0] outv_q, dir_q, cfg_lo_q, cfg_hi_q, mask_q, anye_q;
  logic [PINS-1:0] pad_w, prev_q, hit_w, clr_w, pend_w;
  logic [PINS-1:0] rdata_q;
  logic [2*PINS-1:0] codes_w;
  reg_sel_e        sel;
  logic            addr_ok, wr_ok;

  assign sel     = reg_sel_e'(bus_addr[SEL_MSB:SEL_LSB]);
  assign addr_ok = (bus_addr[ADDR_W-1:SEL_MSB+1] == '0) && (bus_addr[SEL_LSB-1:0] == '0);
  assign wr_ok   = bus_we && addr_ok;

  // Register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      outv_q   <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
      anye_q   <= '0;
    end else if (wr_ok) begin
      unique case (sel)
        SEL_OUTV:   outv_q   <= bus_wdata;
        SEL_DIR:    dir_q    <= bus_wdata;
        SEL_CFG_LO: cfg_lo_q <= bus_wdata;
        SEL_CFG_HI: cfg_hi_q <= bus_wdata;
        SEL_MASK:   mask_q   <= bus_wdata;
        SEL_ANYE:   anye_q   <= bus_wdata;
        default:    ;
      endcase
    end
  end

  assign clr_w = (wr_ok && sel == SEL_PEND) ? bus_wdata : '0;

  // Pin input path
  gpio_sync2 #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pin_in),
    .dout (pad_w)
  );

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= pad_w;
  end

  // Low word packs pins 0..HALF-1, high word the rest: pin n lands at [2n+1:2n]
  assign codes_w = {cfg_hi_q, cfg_lo_q};

  gpio_trig_detect #(.PINS(PINS)) u_detect (
    .cur      (pad_w),
    .old      (prev_q),
    .codes    (codes_w),
    .any_edge (anye_q),
    .hit      (hit_w)
  );

  gpio_irq_status #(.PINS(PINS)) u_status (
    .clk     (clk),
    .rst     (rst),
    .set_vec (hit_w),
    .clr_vec (clr_w),
    .mask    (mask_q),
    .pend    (pend_w),
    .irq     (irq)
  );

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (!addr_ok) begin
      rdata_q <= '0;
    end else begin
      unique case (sel)
        SEL_OUTV:   rdata_q <= outv_q;
        SEL_DIR:    rdata_q <= dir_q;
        SEL_PAD:    rdata_q <= pad_w;
        SEL_CFG_LO: rdata_q <= cfg_lo_q;
        SEL_CFG_HI: rdata_q <= cfg_hi_q;
        SEL_MASK:   rdata_q <= mask_q;
        SEL_PEND:   rdata_q <= pend_w;
        SEL_ANYE:   rdata_q <= anye_q;
        default:    rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign pin_out   = outv_q;
  assign pin_oe    = dir_q;

  // R8: a fully masked port cannot raise the interrupt on the next cycle
  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq);

  // R9: control registers leave reset cleared
  a_r9_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (pin_out == '0 && pin_oe == '0 && !irq));

  initial begin
    if (HALF * 2 != PINS) $error("PINS must be even");
  end

endmodule

// File: tb/gpio_irq_port_tb_top.sv
module gpio_irq_port_tb_top;

  localparam logic [7:0] A_OUTV = 8'h00, A_DIR = 8'h04, A_PAD = 8'h08,
                         A_CLO = 8'h0C, A_CHI = 8'h10, A_MASK = 8'h14,
                         A_PEND = 8'h18, A_ANYE = 8'h1C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_port dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] f_lvl(input logic [63:0] cfg, input logic [31:0] anye,
                                        input logic [31:0] v);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) begin
      if (!anye[i]) begin
        if (cfg[2*i +: 2] == 2'd0) r[i] = !v[i];
        if (cfg[2*i +: 2] == 2'd1) r[i] = v[i];
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] f_edg(input logic [63:0] cfg, input logic [31:0] anye,
                                        input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) begin
      if (anye[i]) r[i] = a[i] ^ b[i];
      else if (cfg[2*i +: 2] == 2'd2) r[i] = !a[i] && b[i];
      else if (cfg[2*i +: 2] == 2'd3) r[i] = a[i] && !b[i];
    end
    return r;
  endfunction

  // Configure, settle on A, clear, move to B, then check pending and irq
  task automatic scenario(input string tag, input logic [31:0] clo, input logic [31:0] chi,
                          input logic [31:0] anye, input logic [31:0] a,
                          input logic [31:0] b, input logic [31:0] m);
    logic [31:0] got, exp;
    logic [63:0] cfg = {chi, clo};
    @(negedge clk) pin_in = a;
    wr(A_MASK, 32'h0);
    wr(A_CLO, clo);
    wr(A_CHI, chi);
    wr(A_ANYE, anye);
    idle(6);
    wr(A_PEND, 32'hFFFF_FFFF);
    idle(6);
    rd(A_PEND, got);
    chk({"R7 level re-set after clear ", tag}, got, f_lvl(cfg, anye, a));
    @(negedge clk) pin_in = b;
    idle(6);
    exp = f_lvl(cfg, anye, a) | f_lvl(cfg, anye, b) | f_edg(cfg, anye, a, b);
    rd(A_PEND, got);
    chk({"R4 R5 pending ", tag}, got, exp);
    rd(A_PAD, got);
    chk({"R3 pad ", tag}, got, b);
    wr(A_MASK, m);
    idle(2);
    chk({"R8 irq ", tag}, {31'b0, irq}, {31'b0, |(exp & m)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    void'($urandom(32'd20517));
    idle(5);
    @(negedge clk) rst = 1'b0;

    // R9: reset state
    chk("R9 pin_out", pin_out, 32'h0);
    chk("R9 pin_oe", pin_oe, 32'h0);
    chk("R9 irq", {31'b0, irq}, 32'h0);
    rd(A_OUTV, got); chk("R9 outv", got, 32'h0);
    rd(A_CLO, got);  chk("R9 cfg lo", got, 32'h0);
    rd(A_CHI, got);  chk("R9 cfg hi", got, 32'h0);
    rd(A_MASK, got); chk("R9 mask", got, 32'h0);
    rd(A_ANYE, got); chk("R9 any-edge", got, 32'h0);
    // R7: default low-level code with low pins sets pending while masked
    rd(A_PEND, got); chk("R7 masked pending", got, 32'hFFFF_FFFF);
    chk("R8 masked irq low", {31'b0, irq}, 32'h0);

    // R1, R2, R3: data, direction, pad
    wr(A_OUTV, 32'hA5A5_0F0F);
    chk("R1 pin_out", pin_out, 32'hA5A5_0F0F);
    @(negedge clk) pin_in = 32'h5A5A_F0F0;
    idle(4);
    rd(A_OUTV, got); chk("R1 readback not pin", got, 32'hA5A5_0F0F);
    wr(A_DIR, 32'hFFFF_0000);
    chk("R2 pin_oe", pin_oe, 32'hFFFF_0000);
    rd(A_PAD, got); chk("R3 pad with outputs", got, 32'h5A5A_F0F0);
    wr(A_PAD, 32'h1234_5678);
    rd(A_PAD, got); chk("R3 pad write ignored", got, 32'h5A5A_F0F0);

    // R10: unmapped and misaligned
    wr(8'h24, 32'hDEAD_BEEF);
    wr(8'h01, 32'hDEAD_BEEF);
    rd(A_OUTV, got); chk("R10 stray writes ignored", got, 32'hA5A5_0F0F);
    rd(8'h20, got);  chk("R10 unmapped read", got, 32'h0);
    rd(8'h06, got);  chk("R10 misaligned read", got, 32'h0);

    // R4: pin 3 rising in low word, pin 17 falling in high word
    scenario("pack up", 32'hAAAA_AAAA, 32'hAAAA_AAAE, 32'h0, 32'h0,
             32'h0002_0008, 32'h0000_0008);
    @(negedge clk) pin_in = 32'h0;
    idle(6);
    rd(A_PEND, got); chk("R4 pin17 fall code", got, 32'h0002_0008);
    // R6: clear only bit 3, bit 17 kept; write of zero changes nothing
    wr(A_PEND, 32'h0000_0008);
    rd(A_PEND, got); chk("R6 partial clear", got, 32'h0002_0000);
    wr(A_PEND, 32'h0);
    rd(A_PEND, got); chk("R6 zero write keeps", got, 32'h0002_0000);

    // R5: any-edge on pin 5 (rise code) and pin 6 (low code)
    scenario("any-edge", 32'hAAAA_AAAA & ~32'h0000_3000, 32'hAAAA_AAAA,
             32'h0000_0060, 32'h0000_0020, 32'h0, 32'h0000_0020);

    // R6: set wins over clear when the level stays present
    scenario("low lvl", 32'h0, 32'h0, 32'h0, 32'h0000_FFFF, 32'h0000_FFFF, 32'h0);
    wr(A_PEND, 32'hFFFF_FFFF);
    rd(A_PEND, got); chk("R6 set wins", got, 32'hFFFF_0000);

    // Random patterns
    for (int n = 0; n < 40; n++) begin
      scenario("random", $urandom, $urandom, $urandom & $urandom & $urandom,
               $urandom, $urandom, $urandom & $urandom);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule